// File: doc/BRIEF.md
# Watchdog Reset Pulse Generator

This block sits behind a watchdog timer and turns its single-cycle timeout event into a timed pulse on an external reset pin. A 32-bit configuration word sets three things: the pulse length, the level the pin takes while the pulse is active, and whether the pin is driven both ways or only pulled low. The pulse length is counted in microsecond ticks. A strobe from the host supplies these ticks, so the block has no clock divider of its own.

The host block decodes the bus and presents one write strobe with a data word. The pulse-length field sits in the low bits and is overwritten on every write. The polarity and drive flags are never written directly. They change only when the top byte of the written word matches one of four command keys, so a routine width update cannot change how the pin behaves. The pin is presented as a value plus an output-enable. With an open-drain setting the block only ever drives the pin low or releases it, and a pad outside this block finishes the job.

Top module: `rstpulse_gen`

## Requirements
- R1: After a synchronous reset the configuration reads 0x000000FF, which is a width of 255, active-low and open-drain. Both pin and output-enable are 0 and no pulse is running.
- R2: A write whose bits 31:24 equal 0xA5 sets bit 31 (polarity: 1 means active-high).
- R3: A write whose bits 31:24 equal 0x5A clears bit 31 (active-low).
- R4: A write whose bits 31:24 equal 0xA8 sets bit 30 (drive: 1 means push-pull). The key 0x8A clears bit 30 (open-drain).
- R5: A write with any other top-byte value, zero included, leaves bits 31:30 unchanged. Bits 29:20 are never changed by a write and stay 0.
- R6: Every write replaces bits 19:0 (the width field) with the written bits 19:0. The new value is readable on the configuration output from the next cycle.
- R7: A timeout event starts a pulse that spans width+1 tick strobes. The pulse ends in the cycle after the tick that finds the remaining count at zero. The pin outputs follow the pulse state one clock later.
- R8: A timeout event that arrives during a pulse reloads the count from the stored width. When an event and a tick fall in the same cycle, the event wins and the tick is not counted.
- R9: If an event and a configuration write fall in the same cycle, the pulse takes the width that was stored before the write.
- R10: In open-drain mode the pin value is always 0 and the output-enable equals the pulse state, whatever the polarity. The pin is never 1 while the output-enable is 0.
- R11: In push-pull mode the output-enable is 1. The pin equals the polarity bit XOR (not pulse-active).
- R12: Tick strobes have no effect while no pulse is running, and the outputs stay at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe from the host decode |
| cfg_wdata_i | input | 32 | Configuration write data (command key in 31:24, width in 19:0) |
| cfg_rdata_o | output | 32 | Stored configuration word |
| tick_us_i | input | 1 | One-cycle microsecond tick strobe |
| timeout_i | input | 1 | One-cycle timeout event from the watchdog |
| rst_pin_o | output | 1 | Registered reset pin value |
| rst_oe_o | output | 1 | Registered reset pin output-enable |

## Verification
Two of the block's functions can fall in the same cycle, and the bench provokes both cases. In the first, a restart event lands on a cycle that also carries a tick strobe, mid-pulse. The bench judges this by whether the pulse then lasts exactly width+1 further ticks, which shows the tick was dropped and the count was reloaded. In the second, an event coincides with a write that shrinks the width. Here the pulse length must match the old width, not the new one. A behavioural model in the bench tracks the stored word, the remaining ticks and the pin outputs, and it is compared with the design on every clock.

// File: rtl/rstpulse_pkg.sv
package rstpulse_pkg;
  localparam int CFG_W      = 32;
  localparam int KEY_LSB    = 24;
  localparam int POL_BIT    = 31;
  localparam int DRIVE_BIT  = 30;

  localparam logic [7:0] KEY_ACT_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW   = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;

  typedef struct packed {
    logic active_high;
    logic push_pull;
  } pin_mode_t;
endpackage

// File: rtl/rstpulse_cfg_reg.sv
module rstpulse_cfg_reg
  import rstpulse_pkg::*;
#(
  parameter int WIDTH_BITS  = 20,
  parameter int RESET_WIDTH = 255
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [CFG_W-1:0]      wdata_i,
  output logic [CFG_W-1:0]      cfg_o,
  output pin_mode_t             mode_o,
  output logic [WIDTH_BITS-1:0] width_o
);
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(RESET_WIDTH);

  logic [CFG_W-1:0] cfg_q;
  logic [7:0]       key;

  assign key = wdata_i[CFG_W-1:KEY_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (wr_i) begin
      cfg_q[WIDTH_BITS-1:0] <= wdata_i[WIDTH_BITS-1:0];
      case (key)
        KEY_ACT_HIGH:  cfg_q[POL_BIT]   <= 1'b1;
        KEY_ACT_LOW:   cfg_q[POL_BIT]   <= 1'b0;
        KEY_PUSH_PULL: cfg_q[DRIVE_BIT] <= 1'b1;
        KEY_OPEN_DRN:  cfg_q[DRIVE_BIT] <= 1'b0;
        default: ;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign cfg_o              = cfg_q;
  assign width_o            = cfg_q[WIDTH_BITS-1:0];
  assign mode_o.active_high = cfg_q[POL_BIT];
  assign mode_o.push_pull   = cfg_q[DRIVE_BIT];

  p_key_hi_r2: assert property (@(posedge clk) disable iff (rst)
    wr_i && key == KEY_ACT_HIGH |=> cfg_q[POL_BIT]);
  p_key_lo_r3: assert property (@(posedge clk) disable iff (rst)
    wr_i && key == KEY_ACT_LOW |=> !cfg_q[POL_BIT]);
  p_key_pp_r4: assert property (@(posedge clk) disable iff (rst)
    wr_i && key == KEY_PUSH_PULL |=> cfg_q[DRIVE_BIT]);
  p_key_od_r4: assert property (@(posedge clk) disable iff (rst)
    wr_i && key == KEY_OPEN_DRN |=> !cfg_q[DRIVE_BIT]);
  p_mode_keep_r5: assert property (@(posedge clk) disable iff (rst)
    wr_i && key != KEY_ACT_HIGH && key != KEY_ACT_LOW &&
    key != KEY_PUSH_PULL && key != KEY_OPEN_DRN
    |=> $stable(cfg_q[CFG_W-1:WIDTH_BITS]));
  p_width_load_r6: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> cfg_q[WIDTH_BITS-1:0] == $past(wdata_i[WIDTH_BITS-1:0]));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(cfg_q));
endmodule

// File: rtl/rstpulse_timer.sv
module rstpulse_timer #(
  parameter int WIDTH_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  event_i,
  input  logic                  tick_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic                  active_o
);
  logic                  active_q;
  logic [WIDTH_BITS-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else if (event_i) begin
      active_q <= 1'b1;
      remain_q <= width_i;
    end else if (active_q && tick_i) begin
      if (remain_q == '0) begin
        active_q <= 1'b0;
      end else begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    event_i |=> active_q && remain_q == $past(width_i));
  p_end_r7: assert property (@(posedge clk) disable iff (rst)
    active_q && tick_i && !event_i && remain_q == '0 |=> !active_q);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    active_q && !tick_i && !event_i |=> active_q && $stable(remain_q));
  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !active_q && !event_i |=> !active_q);
endmodule

// File: rtl/rstpulse_pad.sv
module rstpulse_pad
  import rstpulse_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      active_i,
  input  pin_mode_t mode_i,
  output logic      pin_o,
  output logic      oe_o
);
  logic pin_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (mode_i.push_pull) begin
      oe_q  <= 1'b1;
      pin_q <= mode_i.active_high ^ ~active_i;
    end else begin
      oe_q  <= active_i;
      pin_q <= 1'b0;
    end
  end

  assign pin_o = pin_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/rstpulse_gen.sv
module rstpulse_gen
  import rstpulse_pkg::*;
#(
  parameter int WIDTH_BITS  = 20,
  parameter int RESET_WIDTH = 255
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        tick_us_i,
  input  logic        timeout_i,
  output logic        rst_pin_o,
  output logic        rst_oe_o
);
  pin_mode_t             mode;
  logic [WIDTH_BITS-1:0] width;
  logic                  pulse_active;

  rstpulse_cfg_reg #(
    .WIDTH_BITS (WIDTH_BITS),
    .RESET_WIDTH(RESET_WIDTH)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (cfg_wr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg_rdata_o),
    .mode_o (mode),
    .width_o(width)
  );

  rstpulse_timer #(
    .WIDTH_BITS(WIDTH_BITS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .event_i (timeout_i),
    .tick_i  (tick_us_i),
    .width_i (width),
    .active_o(pulse_active)
  );

  rstpulse_pad u_pad (
    .clk     (clk),
    .rst     (rst),
    .active_i(pulse_active),
    .mode_i  (mode),
    .pin_o   (rst_pin_o),
    .oe_o    (rst_oe_o)
  );

  p_pin_needs_oe_r10: assert property (@(posedge clk) disable iff (rst)
    rst_pin_o |-> rst_oe_o);
  p_od_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(mode.push_pull) |-> rst_oe_o == $past(pulse_active));
  p_pp_oe_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(mode.push_pull) |-> rst_oe_o);
endmodule

// File: tb/rstpulse_gen_tb.sv
module rstpulse_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        timeout = 1'b0;
  logic        tick_en = 1'b0;
  logic        tick_phase = 1'b0;
  logic        force_tick = 1'b0;
  logic        tick;
  logic        rst_pin, rst_oe;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  assign tick = force_tick | (tick_en & tick_phase);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_phase <= ((cyc % 4) == 3);
  end

  rstpulse_gen dut_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr_i   (cfg_wr),
    .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .tick_us_i  (tick),
    .timeout_i  (timeout),
    .rst_pin_o  (rst_pin),
    .rst_oe_o   (rst_oe)
  );

  // behavioural reference
  logic [31:0] m_cfg;
  bit          m_act;
  int          m_left;
  bit          m_pin, m_oe;

  always @(posedge clk) begin
    bit o_act;
    logic [31:0] o_cfg;
    if (rst) begin
      m_cfg = 32'hFF; m_act = 0; m_left = 0; m_pin = 0; m_oe = 0;
    end else begin
      o_act = m_act;
      o_cfg = m_cfg;
      if (o_cfg[30]) begin
        m_oe  = 1;
        m_pin = o_cfg[31] ? o_act : !o_act;
      end else begin
        m_oe  = o_act;
        m_pin = 0;
      end
      if (timeout) begin
        m_act = 1; m_left = int'(o_cfg[19:0]);
      end else if (tick && m_act) begin
        if (m_left == 0) m_act = 0;
        else m_left = m_left - 1;
      end
      if (cfg_wr) begin
        case (cfg_wdata[31:24])
          8'hA5: m_cfg[31] = 1'b1;
          8'h5A: m_cfg[31] = 1'b0;
          8'hA8: m_cfg[30] = 1'b1;
          8'h8A: m_cfg[30] = 1'b0;
          default: ;
        endcase
        m_cfg[19:0] = cfg_wdata[19:0];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (cfg_rdata !== m_cfg || rst_pin !== m_pin || rst_oe !== m_oe) begin
        fails++;
        $display("FAIL %s cycle %0d: cfg=%h pin=%b oe=%b expected cfg=%h pin=%b oe=%b",
                 cur_req, cyc, cfg_rdata, rst_pin, rst_oe, m_cfg, m_pin, m_oe);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic fire();
    timeout = 1'b1;
    @(negedge clk);
    timeout = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", cfg_rdata, 32'h000000FF);
    chk("R1", {30'd0, rst_pin, rst_oe}, 32'd0);
    tick_en = 1'b1;

    cur_req = "R6";
    wr_cfg(32'h00000003);
    chk("R6", cfg_rdata, 32'h00000003);
    cur_req = "R10";
    fire();
    repeat (8) @(negedge clk);
    chk("R10", {30'd0, rst_pin, rst_oe}, 32'd1);
    cur_req = "R7";
    repeat (20) @(negedge clk);

    cur_req = "R2";
    wr_cfg(32'hA5000002);
    chk("R2", cfg_rdata, 32'h80000002);
    cur_req = "R10";
    fire();
    repeat (3) @(negedge clk);
    chk("R10", {30'd0, rst_pin, rst_oe}, 32'd1);
    repeat (20) @(negedge clk);

    cur_req = "R4";
    wr_cfg(32'hA8000004);
    chk("R4", cfg_rdata, 32'hC0000004);
    cur_req = "R11";
    @(negedge clk);
    chk("R11", {30'd0, rst_pin, rst_oe}, 32'd1);
    fire();
    repeat (3) @(negedge clk);
    chk("R11", {30'd0, rst_pin, rst_oe}, 32'd3);
    repeat (25) @(negedge clk);

    cur_req = "R3";
    wr_cfg(32'h5A000004);
    chk("R3", cfg_rdata, 32'h40000004);
    cur_req = "R8";
    fire();
    repeat (9) @(negedge clk);
    timeout = 1'b1; force_tick = 1'b1;
    @(negedge clk);
    timeout = 1'b0; force_tick = 1'b0;
    @(negedge clk);
    chk("R8", {30'd0, rst_pin, rst_oe}, 32'd1);
    cur_req = "R7";
    repeat (30) @(negedge clk);

    cur_req = "R9";
    cfg_wr = 1'b1; cfg_wdata = 32'h00000001; timeout = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0; timeout = 1'b0;
    chk("R9", cfg_rdata, 32'h40000001);
    repeat (30) @(negedge clk);

    cur_req = "R5";
    wr_cfg(32'h12FABCDE);
    chk("R5", cfg_rdata, 32'h400ABCDE);
    wr_cfg(32'h00000002);
    chk("R5", cfg_rdata, 32'h40000002);
    cur_req = "R4";
    wr_cfg(32'h8A000002);
    chk("R4", cfg_rdata, 32'h00000002);

    cur_req = "R12";
    repeat (24) @(negedge clk);
    chk("R12", {30'd0, rst_pin, rst_oe}, 32'd0);
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule